// File: doc/BRIEF.md
# Low-Speed USB Bit Receiver

This block receives packets from a low-speed USB link. It takes the raw D+ and D- line levels, sampled once per clock at eight clocks per bit, and turns them into a stream of bytes. It waits for the line to go idle, finds the end of the sync field, decodes the NRZI line code, drops the stuffed bits and packs the data bits into bytes, least significant bit first. Each finished byte leaves the block with a one-clock valid strobe.

A packet ends when both lines are seen low (single-ended zero) at any bit position of a byte except the first. The first position is exempt because a hub may add one extra bit there. If a packet carries more bytes than the configured buffer holds, the block abandons it and raises an overflow pulse. A sync attempt that breaks off (a K edge, then no further K edge within the search window) raises a sync-error pulse. CRC and PID checks are left to the logic that consumes the bytes.

Top module: `usb_ls_rx`

## Requirements
- R1: While reset is held and right after it, rxByteValid, rxDone, rxOverflow and rxSyncErr are 0, and rxCount and rxByte are 0.
- R2: The receiver hunts for sync only after it has seen D- high (J). With D- held low from reset, the block produces no strobe or pulse of any kind.
- R3: The first clock with D- low after J is taken as a K edge. BIT_CLKS + BIT_CLKS/2 clocks later D- is sampled again. If it is low (a second K), the packet starts. If it is high, the receiver searches for the next K edge.
- R4: The search for the next K edge lasts HUNT_CLKS clocks after the high sample. If D- stays high for that whole time, rxSyncErr pulses for one clock and the receiver again waits for J.
- R5: The first data bit is sampled BIT_CLKS clocks after the second K sample, and each later bit BIT_CLKS clocks after the one before it.
- R6: A data bit decodes to 1 when D- equals its value at the previous bit sample, and to 0 when it differs. The reference before the first data bit is K (D- low).
- R7: Decoded bits are packed least significant bit first. After the eighth bit, rxByte shows the byte and rxByteValid is 1 for exactly one clock.
- R8: After six decoded ones in a row, the next bit is dropped without being stored and the run count restarts. The final sync bit counts as the first one of a run, and each decoded zero restarts the count.
- R9: At bit position 0 of a byte, a single-ended zero (D+ and D- both low) does not end the packet. It is decoded as a line bit from D- alone.
- R10: A single-ended zero at bit positions 1 to 7 ends the packet. rxDone pulses for one clock, rxCount holds the number of complete bytes, and any partial byte is dropped.
- R11: If a byte completes when BUF_BYTES bytes have already been delivered, it is not delivered. rxOverflow pulses for one clock and the receiver waits for J.
- R12: rxCount goes to 0 when a packet starts, goes up by one with each valid byte, and keeps its value until the next packet starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, BIT_CLKS cycles per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| dPlus | input | 1 | D+ line level |
| dMinus | input | 1 | D- line level, high is J |
| rxByte | output | 8 | Last received byte |
| rxByteValid | output | 1 | One-clock strobe for a new byte |
| rxCount | output | $clog2(BUF_BYTES+1) | Bytes received in current or last packet |
| rxDone | output | 1 | One-clock end-of-packet pulse |
| rxOverflow | output | 1 | One-clock overflow abort pulse |
| rxSyncErr | output | 1 | One-clock sync search timeout pulse |

## Verification
The assertions check properties that hold on every cycle: bit samples never fall on adjacent clocks, strobes and pulses last one clock and never coincide, the run count never goes past the stuffing limit, the byte count stays within the buffer size, and the count is stable when the end pulse fires. Whether bytes are decoded correctly can only be shown by the bench. It feeds encoded packets through a behavioural model and compares the outputs on every clock. The scenarios cover stuffing runs that include the sync's final bit, a two-K short sync, a broken sync, a dribbled bit before the end of packet, a packet cut off mid-byte, and an overflow followed by a clean packet.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  typedef enum logic [2:0] {
    ST_WAITJ,
    ST_IDLE,
    ST_CHECK,
    ST_HUNT,
    ST_DATA
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startPkt;   // second K seen: reset bit/byte state
    logic sampleEn;   // centre of a data bit
  } rxStrobe_t;

endpackage

// File: rtl/usb_ls_rx_ctrl.sv
module usb_ls_rx_ctrl
  import usb_ls_rx_pkg::*;
#(
  parameter int BIT_CLKS  = 8,
  parameter int HUNT_CLKS = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lineMinus,
  input  logic      endSeen,
  input  logic      abortOvf,
  output rxStrobe_t strobe,
  output logic      syncErr
);

  localparam int HALF_CLKS = BIT_CLKS / 2;
  localparam int EDGE_LOAD = BIT_CLKS + HALF_CLKS - 1;
  localparam int BIT_LOAD  = BIT_CLKS - 1;
  localparam int HUNT_LOAD = HUNT_CLKS - 1;
  localparam int LOAD_MAX  = (EDGE_LOAD > HUNT_LOAD) ? EDGE_LOAD : HUNT_LOAD;
  localparam int TMR_W     = $clog2(LOAD_MAX + 1);

  rxState_t         state;
  logic [TMR_W-1:0] timer;
  logic             timerZero;

  assign timerZero       = (timer == '0);
  assign strobe.startPkt = (state == ST_CHECK) && timerZero && !lineMinus;
  assign strobe.sampleEn = (state == ST_DATA) && timerZero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_WAITJ;
      timer   <= '0;
      syncErr <= 1'b0;
    end else begin
      syncErr <= 1'b0;
      case (state)
        ST_WAITJ: begin
          if (lineMinus) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (!lineMinus) begin
            state <= ST_CHECK;
            timer <= TMR_W'(EDGE_LOAD);
          end
        end
        ST_CHECK: begin
          if (!timerZero) begin
            timer <= timer - 1'b1;
          end else if (!lineMinus) begin
            state <= ST_DATA;
            timer <= TMR_W'(BIT_LOAD);
          end else begin
            state <= ST_HUNT;
            timer <= TMR_W'(HUNT_LOAD);
          end
        end
        ST_HUNT: begin
          if (!lineMinus) begin
            state <= ST_CHECK;
            timer <= TMR_W'(EDGE_LOAD);
          end else if (timerZero) begin
            state   <= ST_WAITJ;
            syncErr <= 1'b1;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_DATA: begin
          if (timerZero) begin
            timer <= TMR_W'(BIT_LOAD);
            if (endSeen || abortOvf) state <= ST_WAITJ;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: state <= ST_WAITJ;
      endcase
    end
  end

  AST_SAMPLE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.sampleEn |=> !strobe.sampleEn); // R5

  AST_SYNC_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    syncErr |=> !syncErr); // R4

  AST_HUNT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT) |-> (timer <= TMR_W'(HUNT_LOAD))); // R4

endmodule

// File: rtl/usb_ls_rx_datapath.sv
module usb_ls_rx_datapath
  import usb_ls_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BUF_BYTES = 11,
  parameter int STUFF_RUN = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           linePlus,
  input  logic                           lineMinus,
  input  rxStrobe_t                      strobe,
  output logic                           endSeen,
  output logic                           abortOvf,
  output logic [DATA_W-1:0]              rxByte,
  output logic                           rxByteValid,
  output logic [$clog2(BUF_BYTES+1)-1:0] rxCount,
  output logic                           rxDone,
  output logic                           rxOverflow
);

  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CNT_W  = $clog2(BUF_BYTES + 1);

  logic              prevLine;
  logic [ONES_W-1:0] onesCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  byteCnt;

  logic              lineSe0;
  logic              decBit;
  logic              isStuff;
  logic              takeBit;
  logic              lastBit;
  logic [DATA_W-1:0] nextByte;

  assign lineSe0  = !linePlus && !lineMinus;
  assign decBit   = (lineMinus == prevLine);
  assign isStuff  = (onesCnt == ONES_W'(STUFF_RUN));
  assign endSeen  = strobe.sampleEn && lineSe0 && (bitIdx != '0);
  assign takeBit  = strobe.sampleEn && !endSeen && !isStuff;
  assign lastBit  = (bitIdx == IDX_W'(DATA_W - 1));
  assign nextByte = {decBit, shiftReg[DATA_W-1:1]};
  assign abortOvf = takeBit && lastBit && (byteCnt == CNT_W'(BUF_BYTES));
  assign rxCount  = byteCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevLine    <= 1'b0;
      onesCnt     <= '0;
      bitIdx      <= '0;
      shiftReg    <= '0;
      byteCnt     <= '0;
      rxByte      <= '0;
      rxByteValid <= 1'b0;
      rxDone      <= 1'b0;
      rxOverflow  <= 1'b0;
    end else begin
      rxByteValid <= 1'b0;
      rxDone      <= 1'b0;
      rxOverflow  <= 1'b0;
      if (strobe.startPkt) begin
        prevLine <= 1'b0;             // sync ends on K
        onesCnt  <= ONES_W'(1);       // last sync bit is a one
        bitIdx   <= '0;
        shiftReg <= '0;
        byteCnt  <= '0;
      end else if (strobe.sampleEn) begin
        if (endSeen) begin
          rxDone <= 1'b1;
        end else begin
          prevLine <= lineMinus;
          if (isStuff) begin
            onesCnt <= '0;
          end else begin
            onesCnt  <= decBit ? onesCnt + ONES_W'(1) : '0;
            shiftReg <= nextByte;
            if (lastBit) begin
              bitIdx <= '0;
              if (abortOvf) begin
                rxOverflow <= 1'b1;
              end else begin
                rxByteValid <= 1'b1;
                rxByte      <= nextByte;
                byteCnt     <= byteCnt + CNT_W'(1);
              end
            end else begin
              bitIdx <= bitIdx + IDX_W'(1);
            end
          end
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rxByteValid |=> !rxByteValid); // R7

  AST_STUFF_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    onesCnt <= ONES_W'(STUFF_RUN)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    byteCnt <= CNT_W'(BUF_BYTES)); // R11

  AST_DONE_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rxDone |-> $stable(byteCnt)); // R10

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int BIT_CLKS  = 8,
  parameter int HUNT_CLKS = 8,
  parameter int BUF_BYTES = 11,
  parameter int STUFF_RUN = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           dPlus,
  input  logic                           dMinus,
  output logic [7:0]                     rxByte,
  output logic                           rxByteValid,
  output logic [$clog2(BUF_BYTES+1)-1:0] rxCount,
  output logic                           rxDone,
  output logic                           rxOverflow,
  output logic                           rxSyncErr
);

  rxStrobe_t strobe;
  logic      endSeen;
  logic      abortOvf;

  usb_ls_rx_ctrl #(
    .BIT_CLKS (BIT_CLKS),
    .HUNT_CLKS(HUNT_CLKS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .lineMinus(dMinus),
    .endSeen  (endSeen),
    .abortOvf (abortOvf),
    .strobe   (strobe),
    .syncErr  (rxSyncErr)
  );

  usb_ls_rx_datapath #(
    .DATA_W   (8),
    .BUF_BYTES(BUF_BYTES),
    .STUFF_RUN(STUFF_RUN)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .linePlus   (dPlus),
    .lineMinus  (dMinus),
    .strobe     (strobe),
    .endSeen    (endSeen),
    .abortOvf   (abortOvf),
    .rxByte     (rxByte),
    .rxByteValid(rxByteValid),
    .rxCount    (rxCount),
    .rxDone     (rxDone),
    .rxOverflow (rxOverflow)
  );

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rxByteValid, rxDone, rxOverflow, rxSyncErr})); // R10

endmodule

// File: tb/sim_usb_ls_rx.sv
module sim_usb_ls_rx;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 8;
  localparam int HUNT_CLKS  = 8;
  localparam int BUF_BYTES  = 11;
  localparam int CNT_W      = $clog2(BUF_BYTES + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dPlus = 1'b0;
  logic dMinus = 1'b0;
  logic [7:0]       rxByte;
  logic             rxByteValid;
  logic [CNT_W-1:0] rxCount;
  logic             rxDone;
  logic             rxOverflow;
  logic             rxSyncErr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  usb_ls_rx #(
    .BIT_CLKS (BIT_CLKS),
    .HUNT_CLKS(HUNT_CLKS),
    .BUF_BYTES(BUF_BYTES),
    .STUFF_RUN(6)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .dPlus(dPlus), .dMinus(dMinus),
    .rxByte(rxByte), .rxByteValid(rxByteValid), .rxCount(rxCount),
    .rxDone(rxDone), .rxOverflow(rxOverflow), .rxSyncErr(rxSyncErr)
  );

  int nChecks = 0;
  int nErrors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mState = 0;   // 0 wait J, 1 idle, 2 second-K check, 3 edge search, 4 data
  longint cyc = 0;
  longint mDue = 0;
  int mPrev, mOnes, mBits, mAcc;
  int eValid = 0, eByte = 0, eDone = 0, eOvf = 0, eErr = 0, eCount = 0;

  always @(posedge clk) begin
    cyc++;
    eValid = 0; eDone = 0; eOvf = 0; eErr = 0;
    if (!rst_n) begin
      mState = 0; eCount = 0; eByte = 0;
    end else begin
      case (mState)
        0: if (dMinus) mState = 1;
        1: if (!dMinus) begin mState = 2; mDue = cyc + BIT_CLKS + BIT_CLKS / 2; end
        2: if (cyc == mDue) begin
             if (!dMinus) begin
               mState = 4; mDue = cyc + BIT_CLKS;
               mPrev = 0; mOnes = 1; mBits = 0; mAcc = 0; eCount = 0;
             end else begin
               mState = 3; mDue = cyc + HUNT_CLKS;
             end
           end
        3: if (!dMinus) begin mState = 2; mDue = cyc + BIT_CLKS + BIT_CLKS / 2; end
           else if (cyc == mDue) begin eErr = 1; mState = 0; end
        4: if (cyc == mDue) begin
             mDue = cyc + BIT_CLKS;
             if (!dPlus && !dMinus && mBits != 0) begin
               eDone = 1; mState = 0;
             end else begin
               int d;
               d = (int'(dMinus) == mPrev) ? 1 : 0;
               mPrev = int'(dMinus);
               if (mOnes == 6) mOnes = 0;
               else begin
                 mAcc = mAcc | (d << mBits);
                 mOnes = d ? mOnes + 1 : 0;
                 mBits++;
                 if (mBits == 8) begin
                   mBits = 0;
                   if (eCount == BUF_BYTES) begin eOvf = 1; mState = 0; end
                   else begin eValid = 1; eByte = mAcc; eCount++; end
                   mAcc = 0;
                 end
               end
             end
           end
        default: mState = 0;
      endcase
    end
  end

  // ---------------- per-cycle comparison and capture ----------------
  logic [7:0] gotQ[$];
  int doneSeen = 0, ovfSeen = 0, errSeen = 0, lastDoneCnt = -1;
  bit compareOn = 0;

  always @(negedge clk) begin
    if (compareOn) begin
      // R5 timing is covered by matching strobe cycles exactly
      check(int'(rxByteValid) == eValid, "R7", "byte valid strobe", int'(rxByteValid), eValid);
      if (eValid) check(int'(rxByte) == eByte, "R6", "decoded byte", int'(rxByte), eByte);
      check(int'(rxDone) == eDone, "R10", "done pulse", int'(rxDone), eDone);
      check(int'(rxOverflow) == eOvf, "R11", "overflow pulse", int'(rxOverflow), eOvf);
      check(int'(rxSyncErr) == eErr, "R4", "sync error pulse", int'(rxSyncErr), eErr);
      check(int'(rxCount) == eCount, "R12", "byte count", int'(rxCount), eCount);
    end
    if (rxByteValid) gotQ.push_back(rxByte);
    if (rxDone) begin doneSeen++; lastDoneCnt = int'(rxCount); end
    if (rxOverflow) ovfSeen++;
    if (rxSyncErr) errSeen++;
  end

  // ---------------- line encoder ----------------
  int lineLvl = 1;  // 1 J, 0 K, 2 SE0
  int runOnes = 0;
  logic [7:0] txQ[$];

  task automatic driveLevel(input int lvl, input int nBits);
    dPlus  = (lvl == 0);
    dMinus = (lvl == 1);
    repeat (nBits * BIT_CLKS) @(negedge clk);
  endtask

  task automatic putLine(input int bitVal);
    if (bitVal == 0) lineLvl = 1 - lineLvl;
    driveLevel(lineLvl, 1);
  endtask

  task automatic putData(input int bitVal);
    putLine(bitVal);
    if (bitVal != 0) begin
      runOnes++;
      if (runOnes == 6) begin putLine(0); runOnes = 0; end
    end else runOnes = 0;
  endtask

  task automatic sendPacket(input bit shortSync, input int extraBits, input bit dribble);
    lineLvl = 1;
    driveLevel(1, 2);
    if (shortSync) begin
      putLine(0); putLine(1);
    end else begin
      repeat (7) putLine(0);
      putLine(1);
    end
    runOnes = 1;
    foreach (txQ[i]) for (int b = 0; b < 8; b++) putData(int'(txQ[i][b]));
    for (int k = 0; k < extraBits; k++) putData(k % 2);
    if (dribble) driveLevel(lineLvl, 1);
    driveLevel(2, 2);
    lineLvl = 1;
    driveLevel(1, 3);
  endtask

  task automatic clearCapture();
    gotQ.delete(); doneSeen = 0; ovfSeen = 0; errSeen = 0; lastDoneCnt = -1;
  endtask

  task automatic checkBytes(input string req, input int nExp);
    check(gotQ.size() == nExp, req, "byte count captured", gotQ.size(), nExp);
    for (int i = 0; i < nExp && i < gotQ.size(); i++)
      check(gotQ[i] == txQ[i], req, "captured byte", int'(gotQ[i]), int'(txQ[i]));
  endtask

  task automatic runNormal(input string req, input bit shortSync, input int extraBits,
                           input bit dribble);
    clearCapture();
    sendPacket(shortSync, extraBits, dribble);
    checkBytes(req, txQ.size());
    check(doneSeen == 1, req, "done pulses", doneSeen, 1);
    check(lastDoneCnt == txQ.size(), req, "count at done", lastDoneCnt, txQ.size());
  endtask

  // ---------------- stimulus ----------------
  initial begin
    dPlus = 1'b0; dMinus = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(!rxByteValid && !rxDone && !rxOverflow && !rxSyncErr, "R1", "pulses after reset",
          int'({rxByteValid, rxDone, rxOverflow, rxSyncErr}), 0);
    check(rxCount == 0 && rxByte == 0, "R1", "count and byte after reset",
          int'(rxCount) + int'(rxByte), 0);
    compareOn = 1;
    // R2: line low with no prior J must not start anything
    clearCapture();
    repeat (40) @(negedge clk);
    check(doneSeen + errSeen + ovfSeen + gotQ.size() == 0, "R2", "events before J",
          doneSeen + errSeen + ovfSeen + gotQ.size(), 0);
    driveLevel(1, 2);

    // R6 R7 R10 R12: plain packet
    txQ = '{8'hA5, 8'h3C, 8'h00};
    runNormal("R6", 0, 0, 0);
    // R8: long runs of ones
    txQ = '{8'hFF, 8'hFF, 8'h7E};
    runNormal("R8", 0, 0, 0);
    // R8: sync's final one opens the run
    txQ = '{8'h1F, 8'h00};
    runNormal("R8", 0, 0, 0);
    // R3: two K bits alone end the sync
    txQ = '{8'h5A};
    runNormal("R3", 1, 0, 0);

    // R4: K edge, then J with no further K edge
    clearCapture();
    driveLevel(1, 2);
    driveLevel(0, 1);
    driveLevel(1, 4);
    check(errSeen == 1, "R4", "sync error pulses", errSeen, 1);
    check(gotQ.size() == 0 && doneSeen == 0, "R4", "no data after broken sync",
          gotQ.size() + doneSeen, 0);

    // R9: dribbled bit at position 0 before end of packet
    txQ = '{8'hC3};
    runNormal("R9", 0, 0, 1);
    // R10: end of packet in mid byte drops partial byte
    txQ = '{8'h12, 8'h34};
    runNormal("R10", 0, 3, 0);

    // R11: one byte more than the buffer holds
    clearCapture();
    txQ.delete();
    for (int i = 0; i < BUF_BYTES + 1; i++) txQ.push_back(8'(i * 17 + 3));
    sendPacket(0, 0, 0);
    check(ovfSeen == 1, "R11", "overflow pulses", ovfSeen, 1);
    check(doneSeen == 0, "R11", "no done after overflow", doneSeen, 0);
    checkBytes("R11", BUF_BYTES);

    // R12: a clean packet after the overflow restarts the count
    txQ = '{8'h81};
    runNormal("R12", 0, 0, 0);

    repeat (20) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule